// File: doc/BRIEF.md
# Dual-Channel Gain Control Front End

This block is the digital front end that sets the gain words of a two-channel variable-gain amplifier. A two-bit mode input picks how the gain is set. In parallel mode, one shared 6-bit gain bus feeds both channels. Each channel has its own hold input. While that input is low, the channel follows the bus. While it is high, the channel keeps its current gain and ignores the bus. In pulse mode, a rising edge on an up or down pulse input moves the gain of the selected channel by one code. A large change therefore has to pass through every code in between. In serial mode and in the reserved code, both gains stay as they are.

Each channel has an enable input. When a channel is disabled, it raises a power-down output and freezes its stored gain word. The same word is on the output again when the channel is re-enabled. All outputs are registered and update on the clock edge that samples the inputs.

Top module: `gain_ctrl_front`

## Requirements
- R1: The mode_i codes are 2'b11 parallel, 2'b10 pulse, 2'b01 serial and 2'b00 reserved. In serial and reserved mode, neither gain output changes, whatever the bus, hold or pulse inputs do.
- R2: In parallel mode, an enabled channel whose hold input is low shows on its gain output the gain_bus_i value sampled at the previous rising clock edge.
- R3: In parallel mode, while a channel's hold input is high, its gain output keeps its value and changes on gain_bus_i never reach it.
- R4: The two channels share gain_bus_i but are independent. Holding one channel does not stop the other from following the bus.
- R5: When en_a_i or en_b_i is low, that channel's pwr_dn output is 1 one cycle later and its gain output is frozen in every mode. After re-enable, the output still shows the kept gain word.
- R6: While rst_ni is low, both gain outputs are 0 and both pwr_dn outputs are 0.
- R7: In pulse mode, a rising edge on step_up_i raises the selected channel's gain by exactly one. A rising edge on step_dn_i lowers it by one. step_sel_i selects the channel (0 = A, 1 = B). A level held high gives only one step, and rising edges on both inputs in the same cycle give no change.
- R8: In pulse mode, the gain saturates: an up step at 63 stays at 63 and a down step at 0 stays at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 2 | Gain control mode select |
| gain_bus_i | input | 6 | Shared parallel gain bus |
| hold_a_i | input | 1 | Channel A hold (high = keep gain) |
| hold_b_i | input | 1 | Channel B hold (high = keep gain) |
| en_a_i | input | 1 | Channel A enable |
| en_b_i | input | 1 | Channel B enable |
| step_up_i | input | 1 | Pulse mode increment request |
| step_dn_i | input | 1 | Pulse mode decrement request |
| step_sel_i | input | 1 | Pulse mode channel select (0 = A, 1 = B) |
| gain_a_o | output | 6 | Channel A gain word |
| gain_b_o | output | 6 | Channel B gain word |
| pwr_dn_a_o | output | 1 | Channel A power-down |
| pwr_dn_b_o | output | 1 | Channel B power-down |

## Verification
The bench changes the bus while one channel is held and checks that the held output never moves while the other channel follows. A design that treats the hold input as an edge capture, or shares one hold between the channels, leaks these changes through. It also drives the pulse inputs at the saturation codes, holds them at a steady high level, and raises both in the same cycle. These cases catch wrap-around from 63 to 0, repeated stepping on a level, and a one-sided priority between up and down. Finally, it disables a channel while the bus and pulses keep changing, then re-enables it. A design that lets updates through during power-down would show a different gain after re-enable.

// File: rtl/gain_pkg.sv
package gain_pkg;
  localparam int unsigned GAIN_W = 6;

  typedef enum logic [1:0] {
    MODE_RSVD   = 2'b00,
    MODE_SERIAL = 2'b01,
    MODE_PULSE  = 2'b10,
    MODE_PAR    = 2'b11
  } mode_e;

  typedef struct packed {
    logic par;
    logic pulse;
    logic serial;
  } mode_dec_t;
endpackage

// File: rtl/gain_mode_decode.sv
module gain_mode_decode
  import gain_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic [1:0] mode_i,
  output mode_dec_t dec_o
);
  always_comb begin
    dec_o = '0;
    unique case (mode_e'(mode_i))
      MODE_PAR:    dec_o.par    = 1'b1;
      MODE_PULSE:  dec_o.pulse  = 1'b1;
      MODE_SERIAL: dec_o.serial = 1'b1;
      default:     dec_o        = '0;
    endcase
  end

  // R1: at most one mode active
  a_r1_onehot_mode: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({dec_o.par, dec_o.pulse, dec_o.serial}));
endmodule

// File: rtl/gain_step_edge.sv
module gain_step_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic up_i,
  input  logic dn_i,
  output logic inc_o,
  output logic dec_o
);
  logic up_q, dn_q;
  logic up_rise, dn_rise;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      up_q <= 1'b0;
      dn_q <= 1'b0;
    end else begin
      up_q <= up_i;
      dn_q <= dn_i;
    end
  end

  assign up_rise = up_i & ~up_q;
  assign dn_rise = dn_i & ~dn_q;
  // simultaneous edges cancel
  assign inc_o = up_rise & ~dn_rise;
  assign dec_o = dn_rise & ~up_rise;

  a_r7_no_repeat_on_level: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inc_o |=> !inc_o);
  a_r7_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(inc_o && dec_o));
endmodule

// File: rtl/gain_channel.sv
module gain_channel
  import gain_pkg::*;
#(
  parameter int unsigned W = GAIN_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  mode_dec_t    mode_i,
  input  logic [W-1:0] bus_i,
  input  logic         hold_i,
  input  logic         en_i,
  input  logic         sel_i,
  input  logic         inc_i,
  input  logic         dec_i,
  output logic [W-1:0] gain_o,
  output logic         pwr_dn_o
);
  localparam logic [W-1:0] GMAX = {W{1'b1}};
  localparam logic [W-1:0] GMIN = '0;

  logic [W-1:0] gain_q, gain_d;
  logic         pd_q;

  always_comb begin
    gain_d = gain_q;
    if (en_i) begin
      if (mode_i.par && !hold_i) begin
        gain_d = bus_i;
      end else if (mode_i.pulse && sel_i) begin
        if (inc_i && gain_q != GMAX) gain_d = gain_q + 1'b1;
        else if (dec_i && gain_q != GMIN) gain_d = gain_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gain_q <= GMIN;
      pd_q   <= 1'b0;
    end else begin
      gain_q <= gain_d;
      pd_q   <= ~en_i;
    end
  end

  assign gain_o   = gain_q;
  assign pwr_dn_o = pd_q;

  a_r2_follow_bus: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i.par && !hold_i && en_i) |=> gain_q == $past(bus_i));
  a_r3_hold_keeps: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i.par && hold_i) |=> $stable(gain_q));
  a_r1_idle_mode_keeps: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mode_i.par && !mode_i.pulse) |=> $stable(gain_q));
  a_r5_disabled_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> ($stable(gain_q) && pd_q));
  a_r7_single_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_i.pulse |=> (gain_q == $past(gain_q) || gain_q == $past(gain_q) + 1'b1
                      || gain_q == $past(gain_q) - 1'b1));
  a_r8_top_saturate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i.pulse && gain_q == GMAX) |=> gain_q != GMIN);
  a_r8_bottom_saturate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i.pulse && gain_q == GMIN) |=> gain_q != GMAX);
endmodule

// File: rtl/gain_ctrl_front.sv
module gain_ctrl_front
  import gain_pkg::*;
#(
  parameter int unsigned W = GAIN_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [1:0]   mode_i,
  input  logic [W-1:0] gain_bus_i,
  input  logic         hold_a_i,
  input  logic         hold_b_i,
  input  logic         en_a_i,
  input  logic         en_b_i,
  input  logic         step_up_i,
  input  logic         step_dn_i,
  input  logic         step_sel_i,
  output logic [W-1:0] gain_a_o,
  output logic [W-1:0] gain_b_o,
  output logic         pwr_dn_a_o,
  output logic         pwr_dn_b_o
);
  localparam int unsigned NCH = 2;

  mode_dec_t     dec;
  logic          inc, dec_step;
  logic [NCH-1:0] hold_v, en_v, sel_v, pd_v;
  logic [W-1:0]  gain_v [NCH];

  assign hold_v = {hold_b_i, hold_a_i};
  assign en_v   = {en_b_i, en_a_i};
  assign sel_v  = {step_sel_i, ~step_sel_i};

  gain_mode_decode u_mode (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .mode_i(mode_i),
    .dec_o (dec)
  );

  gain_step_edge u_edge (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .up_i  (step_up_i),
    .dn_i  (step_dn_i),
    .inc_o (inc),
    .dec_o (dec_step)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    gain_channel #(.W(W)) u_ch (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .mode_i  (dec),
      .bus_i   (gain_bus_i),
      .hold_i  (hold_v[c]),
      .en_i    (en_v[c]),
      .sel_i   (sel_v[c]),
      .inc_i   (inc),
      .dec_i   (dec_step),
      .gain_o  (gain_v[c]),
      .pwr_dn_o(pd_v[c])
    );
  end

  assign gain_a_o   = gain_v[0];
  assign gain_b_o   = gain_v[1];
  assign pwr_dn_a_o = pd_v[0];
  assign pwr_dn_b_o = pd_v[1];

  // R4: held channel stays put while the other tracks the bus
  a_r4_independent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec.par && hold_a_i && !hold_b_i && en_b_i) |=>
      ($stable(gain_a_o) && gain_b_o == $past(gain_bus_i)));
endmodule

// File: tb/gain_ctrl_front_tb.sv
`timescale 1ns/1ps
module gain_ctrl_front_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] mode = 2'b11;
  logic [5:0] bus = '0;
  logic       ha = 0, hb = 0, ea = 1, eb = 1, up = 0, dn = 0, sel = 0;
  logic [5:0] ga, gb;
  logic       pda, pdb;

  int checks = 0, errors = 0;
  bit done = 0;

  typedef struct {
    logic [5:0] ga, gb;
    logic       pda, pdb;
    string      tag;
  } exp_t;
  exp_t q[$];

  int m_ga = 0, m_gb = 0;
  logic p_up = 0, p_dn = 0;

  always #4 clk = ~clk;

  gain_ctrl_front u_dut (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode), .gain_bus_i(bus),
    .hold_a_i(ha), .hold_b_i(hb), .en_a_i(ea), .en_b_i(eb),
    .step_up_i(up), .step_dn_i(dn), .step_sel_i(sel),
    .gain_a_o(ga), .gain_b_o(gb), .pwr_dn_a_o(pda), .pwr_dn_b_o(pdb)
  );

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int next_gain(int g, bit en, bit hold, bit mine, bit inc, bit dcr);
    if (!en) return g;
    if (mode == 2'b11) return hold ? g : int'(bus);
    if (mode == 2'b10 && mine) begin
      if (inc && g != 63) return g + 1;
      if (dcr && g != 0)  return g - 1;
    end
    return g;
  endfunction

  // driver: apply one cycle of stimulus and queue the expected result
  task automatic step(logic [1:0] m, logic [5:0] b, logic h_a, logic h_b,
                      logic e_a, logic e_b, logic u, logic d, logic s, string tag);
    exp_t e;
    bit inc, dcr;
    @(negedge clk);
    mode = m; bus = b; ha = h_a; hb = h_b; ea = e_a; eb = e_b; up = u; dn = d; sel = s;
    inc = (u && !p_up) && !(d && !p_dn);
    dcr = (d && !p_dn) && !(u && !p_up);
    p_up = u; p_dn = d;
    m_ga = next_gain(m_ga, e_a, h_a, !s, inc, dcr);
    m_gb = next_gain(m_gb, e_b, h_b, s, inc, dcr);
    e.ga = 6'(m_ga); e.gb = 6'(m_gb); e.pda = !e_a; e.pdb = !e_b; e.tag = tag;
    q.push_back(e);
  endtask

  // monitor
  always @(posedge clk) begin
    #2;
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      chk({e.tag, " gain_a"}, ga, e.ga);
      chk({e.tag, " gain_b"}, gb, e.gb);
      chk({e.tag, " pwr_dn_a"}, pda, e.pda);
      chk({e.tag, " pwr_dn_b"}, pdb, e.pdb);
    end
  end

  initial begin
    #(8 * 100000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #20;
    chk("R6 reset gain_a", ga, 0);
    chk("R6 reset gain_b", gb, 0);
    chk("R6 reset pwr_dn_a", pda, 0);
    chk("R6 reset pwr_dn_b", pdb, 0);
    @(negedge clk); rst_n = 1'b1;

    // R2 transparent parallel, several patterns
    step(2'b11, 6'd21, 0, 0, 1, 1, 0, 0, 0, "R2 transparent");
    step(2'b11, 6'd42, 0, 0, 1, 1, 0, 0, 0, "R2 transparent");
    step(2'b11, 6'd63, 0, 0, 1, 1, 0, 0, 0, "R2 transparent");
    step(2'b11, 6'd0,  0, 0, 1, 1, 0, 0, 0, "R2 transparent");
    step(2'b11, 6'd37, 0, 0, 1, 1, 0, 0, 0, "R2 transparent");
    // R3/R4 hold A, B follows
    step(2'b11, 6'd5,  1, 0, 1, 1, 0, 0, 0, "R3 hold_a");
    step(2'b11, 6'd58, 1, 0, 1, 1, 0, 0, 0, "R4 hold_a b_follows");
    step(2'b11, 6'd9,  1, 0, 1, 1, 0, 0, 0, "R3 hold_a bus_ignored");
    // hold B, A follows
    step(2'b11, 6'd17, 0, 1, 1, 1, 0, 0, 0, "R4 hold_b a_follows");
    step(2'b11, 6'd44, 0, 1, 1, 1, 0, 0, 0, "R3 hold_b bus_ignored");
    step(2'b11, 6'd44, 1, 1, 1, 1, 0, 0, 0, "R3 both_hold");
    step(2'b11, 6'd1,  1, 1, 1, 1, 0, 0, 0, "R3 both_hold");
    // R1 serial and reserved keep gain
    step(2'b01, 6'd30, 0, 0, 1, 1, 1, 0, 0, "R1 serial");
    step(2'b01, 6'd31, 0, 0, 1, 1, 0, 0, 1, "R1 serial");
    step(2'b00, 6'd12, 0, 0, 1, 1, 1, 0, 1, "R1 reserved");
    step(2'b00, 6'd13, 0, 0, 1, 1, 0, 1, 0, "R1 reserved");
    // R5 disable A in parallel
    step(2'b11, 6'd50, 0, 0, 1, 1, 0, 0, 0, "R2 reload");
    step(2'b11, 6'd3,  0, 0, 0, 1, 0, 0, 0, "R5 disable_a");
    step(2'b11, 6'd60, 0, 0, 0, 1, 0, 0, 0, "R5 disabled_a");
    step(2'b10, 6'd60, 0, 0, 0, 1, 1, 0, 0, "R5 disabled_a pulse");
    step(2'b10, 6'd60, 0, 0, 0, 1, 0, 0, 0, "R5 disabled_a pulse");
    step(2'b01, 6'd60, 0, 0, 1, 0, 0, 0, 0, "R5 reenable_a disable_b");
    step(2'b11, 6'd22, 1, 0, 1, 0, 0, 0, 0, "R5 disabled_b parallel");
    step(2'b01, 6'd22, 0, 0, 1, 1, 0, 0, 0, "R5 reenable_b");
    // R7/R8 pulse on A: load 61 then step past 63
    step(2'b11, 6'd61, 0, 0, 1, 1, 0, 0, 0, "R2 load61");
    for (int i = 0; i < 4; i++) begin
      step(2'b10, 6'd0, 0, 0, 1, 1, 1, 0, 0, "R8 up_to_top");
      step(2'b10, 6'd0, 0, 0, 1, 1, 0, 0, 0, "R8 up_to_top");
    end
    // level held high: one step only
    step(2'b10, 6'd0, 0, 0, 1, 1, 0, 1, 0, "R7 down");
    step(2'b10, 6'd0, 0, 0, 1, 1, 0, 1, 0, "R7 level_held");
    step(2'b10, 6'd0, 0, 0, 1, 1, 0, 1, 0, "R7 level_held");
    step(2'b10, 6'd0, 0, 0, 1, 1, 0, 0, 0, "R7 release");
    // both edges same cycle
    step(2'b10, 6'd0, 0, 0, 1, 1, 1, 1, 0, "R7 both_edges");
    step(2'b10, 6'd0, 0, 0, 1, 1, 0, 0, 0, "R7 release");
    // pulse on B down through zero
    step(2'b11, 6'd1, 1, 0, 1, 1, 0, 0, 1, "R2 load_b1");
    for (int i = 0; i < 3; i++) begin
      step(2'b10, 6'd9, 0, 0, 1, 1, 0, 1, 1, "R8 down_to_bottom");
      step(2'b10, 6'd9, 0, 0, 1, 1, 0, 0, 1, "R8 down_to_bottom");
    end
    step(2'b10, 6'd9, 0, 0, 1, 1, 1, 0, 1, "R7 up_b");
    step(2'b10, 6'd9, 0, 0, 1, 1, 0, 0, 1, "R7 up_b");
    repeat (3) @(negedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule